// File: doc/BRIEF.md
# Free-Running Timer with Compare Clear

This block is a 16-bit up counter that acts as the common time base for a set of capture and compare channels. It advances once per prescaled tick. The tick comes from the machine clock divided by 4, 16, 32 or 64. The current count is always visible on `count_out`, so neighbouring capture and compare units can sample it without any bus access.

Software reaches the block through a two-entry register port.
- **Address 0** is the counter itself, which software can read and write.
- **Address 1** is an 8-bit control/status byte. It selects the tick rate, can halt counting, can clear the counter, enables the compare-driven clear mode and holds the overflow flag with its interrupt enable.

When the mode bit is set, a match pulse from compare channel 0 returns the counter to zero. This gives a programmable period.

A two-state run controller sits at the centre of the block. `ST_COUNT` is the state in which the prescaler advances. `ST_HALT` is the state in which both the prescaler and the counter hold. Two transitions connect them:
- **HALT_ENTER** (`ST_COUNT` to `ST_HALT`) is taken on a control write with the stop bit at 1.
- **HALT_LEAVE** (`ST_HALT` to `ST_COUNT`) is taken on a control write with the stop bit at 0.

Reset places the controller in `ST_COUNT`.

Top module: `frt_timebase`

## Requirements
- R1: The counter increases by exactly one on each tick, is driven continuously on `count_out`, and wraps from 0xFFFF to 0x0000.
- R2: Control bits [1:0] select the tick period in machine clocks: 00 selects 4, 01 selects 16, 10 selects 32 and 11 selects 64. After any clear, the first tick lands that many clocks later.
- R3: After reset, `count_out` is 0x0000, the control byte reads 0x00 and `irq` is 0.
- R4: Writing a control byte with bit 2 at 1 zeroes both the counter and the prescaler. Bit 2 and bit 7 of the control byte always read 0.
- R5: While control bit 3 (mode) is 1, a `cmp0_match` pulse zeroes the counter and the prescaler and sets the flag. While mode is 0, the pulse has no effect on the count or the flag.
- R6: While control bit 4 (stop) reads 1, the count and the prescaler hold. A clear still applies during this time.
- R7: Control bit 6 (flag) is set on the tick that wraps the count, and on a compare clear. Writing 0 to it clears it and writing 1 has no effect. A hardware set in the same cycle as a clearing write wins.
- R8: `irq` is 1 exactly while the flag and control bit 5 (interrupt enable) are both 1.
- R9: Address 0 reads and writes the counter. A counter write in the same cycle as a tick stores the written value, not the value plus one.
- R10: Control bits 6, 5, 4, 3, 1 and 0 read back the flag and the last written enable, stop, mode and select values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the counter, 1 selects the control byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| cmp0_match | input | 1 | Match pulse from compare channel 0 |
| count_out | output | 16 | Current count for the capture and compare units |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same clock.
- **Flag set against flag clear.** A compare-clear match is raised in the very cycle that software writes 0 to an already set flag. The flag must still read 1 afterwards.
- **Counter write against tick.** A counter write is issued on the exact clock where a tick is due, which the bench knows by counting clocks from a preceding clear. The written value must appear unchanged, and the next increment must follow one full period later.

Both cases are judged at the ports against values the bench derives from the clock count since the last clear.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_HALT  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic       ie;
        logic       mode;
        logic [1:0] sel;
    } frt_cfg_t;

    localparam int unsigned BIT_FLAG  = 6;
    localparam int unsigned BIT_IE    = 5;
    localparam int unsigned BIT_STOP  = 4;
    localparam int unsigned BIT_MODE  = 3;
    localparam int unsigned BIT_CLR   = 2;
    localparam int unsigned MAX_SHIFT = 6;

    function automatic int unsigned div_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2;
            2'b01:   return 4;
            2'b10:   return 5;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/frt_prescale.sv
module frt_prescale
    import frt_pkg::*;
#(
    parameter int unsigned PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    always_comb limit = PRE_W'((32'd1 << div_shift(sel)) - 32'd1);

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else if (run)     cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/frt_count.sv
module frt_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    // a wrap counts only when the tick is actually applied
    assign wrap = tick && !load && !clear && (count == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (clear) count <= '0;
        else if (tick)  count <= count + 1'b1;
    end

endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl
    import frt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [6:0] wdata,
    input  logic       hw_set,
    output frt_cfg_t   cfg,
    output logic       halted,
    output logic       flag,
    output logic       sw_clr,
    output logic       irq
);

    run_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // next state: HALT_ENTER / HALT_LEAVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (ctrl_wr &&  wdata[BIT_STOP]) state_d = ST_HALT;
            ST_HALT:  if (ctrl_wr && !wdata[BIT_STOP]) state_d = ST_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        halted = (state_q == ST_HALT);
        sw_clr = ctrl_wr && wdata[BIT_CLR];
        irq    = flag && cfg.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.ie   <= wdata[BIT_IE];
            cfg.mode <= wdata[BIT_MODE];
            cfg.sel  <= wdata[1:0];
        end
    end

    // hardware set wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           flag <= 1'b0;
        else if (hw_set)                      flag <= 1'b1;
        else if (ctrl_wr && !wdata[BIT_FLAG]) flag <= 1'b0;
    end

endmodule

// File: rtl/frt_timebase.sv
module frt_timebase
    import frt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             cmp0_match,
    output logic [CNT_W-1:0] count_out,
    output logic             irq
);

    localparam int unsigned PRE_W      = MAX_SHIFT;
    localparam logic        ADDR_COUNT = 1'b0;

    frt_cfg_t cfg;
    logic     halted, flag, sw_clr, tick, wrap;
    logic     cnt_wr, ctrl_wr, cmp_clr, restart;

    assign cnt_wr  = reg_wr && (reg_addr == ADDR_COUNT);
    assign ctrl_wr = reg_wr && (reg_addr != ADDR_COUNT);
    assign cmp_clr = cmp0_match && cfg.mode;
    assign restart = sw_clr || cmp_clr;

    frt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata[6:0]),
        .hw_set  (wrap || cmp_clr),
        .cfg     (cfg),
        .halted  (halted),
        .flag    (flag),
        .sw_clr  (sw_clr),
        .irq     (irq)
    );

    frt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!halted),
        .restart (restart),
        .sel     (cfg.sel),
        .tick    (tick)
    );

    frt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (reg_wdata),
        .clear    (restart),
        .tick     (tick),
        .count    (count_out),
        .wrap     (wrap)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_COUNT) reg_rdata = count_out;
        else reg_rdata[7:0] = {1'b0, flag, cfg.ie, halted, cfg.mode, 1'b0, cfg.sel};
    end

endmodule

// File: rtl/frt_timebase_chk.sv
module frt_timebase_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic             flag_wbit,
    input logic             clr_wbit,
    input logic             cmp0_match,
    input logic [CNT_W-1:0] count_out,
    input logic             irq,
    input logic             mode,
    input logic             ie,
    input logic             halted,
    input logic             flag
);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !(cmp0_match && mode)) |=>
        (count_out == $past(count_out) || count_out == CNT_W'($past(count_out) + 1'b1)));

    // R4
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && clr_wbit) |=> (count_out == '0));

    // R5
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp0_match && mode && !(reg_wr && !reg_addr)) |=> (count_out == '0 && flag));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !reg_wr && !(cmp0_match && mode)) |=> $stable(count_out));

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out == '1 && !reg_wr && !(cmp0_match && mode)) |=> (count_out == '1 || flag));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr && reg_addr && !flag_wbit)) |=> flag);

    // R8
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie && flag));

endmodule

bind frt_timebase frt_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .flag_wbit  (reg_wdata[6]),
    .clr_wbit   (reg_wdata[2]),
    .cmp0_match (cmp0_match),
    .count_out  (count_out),
    .irq        (irq),
    .mode       (cfg.mode),
    .ie         (cfg.ie),
    .halted     (halted),
    .flag       (flag)
);

// File: tb/frt_timebase_bench.sv
module frt_timebase_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmp0_match = 1'b0;
    logic [15:0] count_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frt_timebase u_frt_timebase (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp0_match(cmp0_match),
        .count_out(count_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic cmp_pulse();
        cmp0_match = 1'b1;
        @(negedge clk);
        cmp0_match = 1'b0;
    endtask

    function automatic int period(input int sel);
        return (sel == 0) ? 4 : (sel == 1) ? 16 : (sel == 2) ? 32 : 64;
    endfunction

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state
        chk("R3 count", count_out, 0);
        rd(1'b1, v); chk("R3 ctrl", v, 0);
        chk("R3 irq", irq, 0);

        // R2 / R1: sweep every select code
        for (int sel = 0; sel < 4; sel++) begin
            wr(1'b1, 16'h0004 | 16'(sel));
            for (int n = 0; n < 4 * period(sel) + 4; n++) begin
                chk($sformatf("R2 sel%0d n%0d", sel, n), count_out, n / period(sel));
                @(negedge clk);
            end
        end

        // R6 stop halts counting
        wr(1'b1, 16'h0014);
        rd(1'b1, v); chk("R10 stop readback", v, 16'h10);
        for (int n = 0; n < 40; n++) begin
            chk("R6 held", count_out, 0);
            @(negedge clk);
        end
        wr(1'b1, 16'h0004);
        for (int n = 0; n < 20; n++) begin
            chk("R6 resumed", count_out, n / 4);
            @(negedge clk);
        end

        // R1 / R7 wrap and flag
        wr(1'b1, 16'h0004);
        wr(1'b0, 16'hFFF0);
        for (int m = 1; m < 71; m++) begin
            chk("R1 wrap count", count_out, 16'(32'hFFF0 + m / 4));
            rd(1'b1, v);
            chk("R7 wrap flag", v[6], (m >= 64) ? 1 : 0);
            @(negedge clk);
        end
        rd(1'b1, v); chk("R10 flag readback", v, 16'h40);
        chk("R8 irq masked", irq, 0);
        wr(1'b1, 16'h0060);
        rd(1'b1, v); chk("R7 write1 no effect", v, 16'h60);
        chk("R8 irq high", irq, 1);
        wr(1'b1, 16'h0020);
        rd(1'b1, v); chk("R7 write0 clears", v, 16'h20);
        chk("R8 irq low", irq, 0);

        // R9 counter write beats a due tick
        wr(1'b1, 16'h0004);
        repeat (3) @(negedge clk);
        wr(1'b0, 16'h1234);
        chk("R9 write wins", count_out, 16'h1234);
        repeat (3) @(negedge clk);
        chk("R9 held period", count_out, 16'h1234);
        @(negedge clk);
        chk("R9 next tick", count_out, 16'h1235);
        rd(1'b0, v); chk("R9 readback", v, 16'h1235);

        // R5 compare clear with mode set
        wr(1'b1, 16'h000C);
        repeat (10) @(negedge clk);
        chk("R5 before match", count_out, 2);
        cmp_pulse();
        for (int m = 0; m < 12; m++) begin
            chk("R5 after match", count_out, m / 4);
            @(negedge clk);
        end
        rd(1'b1, v); chk("R5 flag set", v, 16'h48);

        // R5 mode clear: match ignored
        wr(1'b1, 16'h0004);
        repeat (10) @(negedge clk);
        cmp_pulse();
        chk("R5 ignored count", count_out, 2);
        rd(1'b1, v); chk("R5 ignored flag", v[6], 0);
        repeat (2) @(negedge clk);
        chk("R5 ignored continue", count_out, 3);

        // R7 hardware set beats a clearing write in the same cycle
        wr(1'b1, 16'h000C);
        cmp_pulse();
        rd(1'b1, v); chk("R7 flag pre", v[6], 1);
        cmp0_match = 1'b1;
        wr(1'b1, 16'h0008);
        cmp0_match = 1'b0;
        rd(1'b1, v); chk("R7 set wins", v, 16'h48);
        chk("R5 concurrent clear", count_out, 0);

        // R4 clear bit and reserved bit read 0
        repeat (9) @(negedge clk);
        wr(1'b1, 16'h0084);
        chk("R4 clear count", count_out, 0);
        rd(1'b1, v); chk("R4 readback", v, 16'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule